// File: doc/BRIEF.md
# Adaptive Half-Bridge Dead-Time Compensator

This block turns a phase request from an oscillator into two gate commands for a half bridge, one for the high-side switch and one for the low-side switch. It never drives both at once. Between the two on-phases it inserts a dead time. The low-to-high dead time is measured. After the low-side command drops, the block waits for a digitized midpoint-sense comparator to report that the bridge midpoint has risen. It then waits a further fixed delay before turning the high side on. The whole interval therefore contains the storage time of slow switches, and the block stores it. It then replays the stored interval as the dead time from the high-side fall to the next low-side rise. With fast switches the midpoint rises at once, so both dead times equal the fixed delay.

Each on-phase lasts at least a minimum number of cycles, even when the request flips back sooner. A watchdog supervises how long a run of such stretched phases may last. If the run lasts too long, the block latches a fault and holds both outputs low until reset. If the midpoint sense never arrives, a timeout forces the high-side turn-on and clamps the measured interval.

Top module: `hb_deadtime_ctrl`

## Requirements
- R1: `hs_on` and `ls_on` are never high together. During reset `hs_on`, `ls_on` and `fault` are low. The stored interval resets to DEAD_CYC, so `ls_on` rises DEAD_CYC cycles after reset is released.
- R2: After `ls_on` falls, let k be the number of whole cycles before `mid_hi` is first sampled high. `hs_on` then rises after k + DEAD_CYC cycles with both outputs low. When `mid_hi` is high in the first cycle (k = 0), the dead time is exactly DEAD_CYC cycles.
- R3: If k + DEAD_CYC would exceed MAX_DEAD_CYC, `hs_on` is forced on after MAX_DEAD_CYC cycles with both outputs low. The stored interval is then MAX_DEAD_CYC.
- R4: The number of cycles with both outputs low between the fall of `hs_on` and the next rise of `ls_on` equals the most recently stored low-to-high dead time.
- R5: An on-phase ends one cycle after the request for the opposite side is seen. It never lasts fewer than MIN_ON_CYC cycles. The width of a phase whose request lasted L cycles is therefore max(L, MIN_ON_CYC).
- R6: The phase timer saturates at 2^CNT_W - 1 instead of wrapping. An on-phase longer than 2^CNT_W cycles is not stretched when it ends.
- R7: An on-phase is "stretched" when an opposite request arrived before its minimum time elapsed. After a stretched phase ends, a watchdog counts cycles. If the following phases are also stretched and WD_CYC cycles pass, `fault` rises and both outputs go low.
- R8: An on-phase that ends without being stretched clears the watchdog. Alternating stretched and clean phases never raise `fault`, however long they continue.
- R9: Once `fault` is high it stays high, and both outputs stay low whatever `phase_hi` and `mid_hi` do. Only reset clears it, after which the R1 start-up sequence repeats.
- R10: Once `ls_on` has fallen, the switch to the high side is committed. If the request reverts during the dead time, `hs_on` still turns on and is then held for MIN_ON_CYC cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase_hi | input | 1 | Phase request: 1 asks for the high side, 0 for the low side |
| mid_hi | input | 1 | Synchronized midpoint comparator: 1 when the midpoint is above threshold |
| hs_on | output | 1 | High-side gate command |
| ls_on | output | 1 | Low-side gate command |
| fault | output | 1 | Latched shutdown flag |

## Verification
The bench builds the block with DEAD_CYC = 4, MIN_ON_CYC = 6, MAX_DEAD_CYC = 20, CNT_W = 6 and WD_CYC = 100. These values make the timeout clamp reachable with a midpoint delay of only 16 cycles. They also let a 66-cycle on-phase overrun the 6-bit timer and test saturation. The watchdog trip and its restart both fall within a few hundred cycles. A behavioural midpoint model raises the sense input a chosen number of cycles after the low side falls. With it the bench sweeps the measured dead time through the fixed value, the storage-extended values, the exact clamp boundary and a missing sense, and compares each replayed dead time against the one measured before it.

// File: rtl/hb_deadtime_ctrl.sv
module hb_deadtime_ctrl #(
  parameter int DEAD_CYC     = 71,
  parameter int MIN_ON_CYC   = 50,
  parameter int MAX_DEAD_CYC = 250,
  parameter int CNT_W        = 8,
  parameter int WD_CYC       = 10_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic phase_hi,
  input  logic mid_hi,
  output logic hs_on,
  output logic ls_on,
  output logic fault
);

  localparam int WD_W = $clog2(WD_CYC + 1);
  localparam logic [CNT_W-1:0] TMAX    = '1;
  localparam logic [CNT_W-1:0] DEAD_L  = CNT_W'(DEAD_CYC - 1);
  localparam logic [CNT_W-1:0] DEAD_N  = CNT_W'(DEAD_CYC);
  localparam logic [CNT_W-1:0] MINON_L = CNT_W'(MIN_ON_CYC - 1);
  localparam logic [CNT_W-1:0] MAXD_L  = CNT_W'(MAX_DEAD_CYC - 1);
  localparam logic [CNT_W-1:0] MAXD_N  = CNT_W'(MAX_DEAD_CYC);
  localparam logic [WD_W-1:0]  WD_L    = WD_W'(WD_CYC - 1);

  typedef enum logic [2:0] {ST_LS, ST_DLH, ST_HS, ST_DHL, ST_FLT} st_t;

  st_t              state, nxt;
  logic [CNT_W-1:0] tmr, dcnt, dt_st;
  logic             seen, held, strk;
  logic [WD_W-1:0]  wd;

  wire on_st    = (state == ST_LS) || (state == ST_HS);
  wire want_sw  = (state == ST_LS && phase_hi) || (state == ST_HS && !phase_hi);
  wire min_met  = tmr >= MINON_L;
  wire sense_ok = seen || mid_hi;
  wire [CNT_W-1:0] pos = seen ? dcnt : '0;
  wire lh_done  = (sense_ok && pos == DEAD_L) || (tmr == MAXD_L);
  wire hl_done  = tmr == dt_st - 1'b1;
  wire wd_trip  = strk && (wd == WD_L);

  always_comb begin
    nxt = state;
    case (state)
      ST_LS:   if (want_sw && min_met) nxt = ST_DLH;
      ST_DLH:  if (lh_done) nxt = ST_HS;
      ST_HS:   if (want_sw && min_met) nxt = ST_DHL;
      ST_DHL:  if (hl_done) nxt = ST_LS;
      default: nxt = ST_FLT;
    endcase
    if (wd_trip) nxt = ST_FLT;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_DHL;
      tmr   <= '0;
      dcnt  <= '0;
      seen  <= 1'b0;
      dt_st <= DEAD_N;
      held  <= 1'b0;
      strk  <= 1'b0;
      wd    <= '0;
    end else begin
      state <= nxt;

      if (nxt != state)     tmr <= '0;
      else if (tmr != TMAX) tmr <= tmr + 1'b1;

      if (state == ST_DLH && nxt == ST_DLH) begin
        if (seen) dcnt <= dcnt + 1'b1;
        else if (mid_hi) begin
          seen <= 1'b1;
          dcnt <= CNT_W'(1);
        end
      end else begin
        seen <= 1'b0;
        dcnt <= '0;
      end

      if (state == ST_DLH && nxt == ST_HS) dt_st <= tmr + 1'b1;

      if (nxt != state)                        held <= 1'b0;
      else if (on_st && want_sw && !min_met)   held <= 1'b1;

      if (on_st && nxt != state) begin
        strk <= held;
        if (!held)                    wd <= '0;
        else if (strk && wd != WD_L)  wd <= wd + 1'b1;
      end else if (strk && wd != WD_L) begin
        wd <= wd + 1'b1;
      end
    end
  end

  assign hs_on = (state == ST_HS);
  assign ls_on = (state == ST_LS);
  assign fault = (state == ST_FLT);

  a_r1_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_on && ls_on)) else $error("R1 both outputs on");

  a_r2_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ls_on) |=> !hs_on) else $error("R2 no dead time after low side");

  a_r3_meas_range: assert property (@(posedge clk) disable iff (!rst_n)
    (dt_st >= DEAD_N) && (dt_st <= MAXD_N)) else $error("R3 stored interval out of range");

  a_r3_forced: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DLH && tmr == MAXD_L && !wd_trip) |=> hs_on) else $error("R3 timeout not forced");

  a_r5_min_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (on_st && !min_met && !wd_trip) |=> (state == $past(state))) else $error("R5 phase cut short");

  a_r6_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (on_st && tmr == TMAX && nxt == state) |=> (tmr == TMAX)) else $error("R6 timer wrapped");

  a_r9_latched: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> (fault && !hs_on && !ls_on)) else $error("R9 fault released");

  a_r10_commit: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DLH && !wd_trip) |=> (state == ST_DLH || hs_on)) else $error("R10 switch aborted");

endmodule

// File: tb/hb_deadtime_ctrl_tb_top.sv
`timescale 1ns/1ps
module hb_deadtime_ctrl_tb_top;
  localparam int D  = 4;
  localparam int MN = 6;
  localparam int MX = 20;
  localparam int CW = 6;
  localparam int WD = 100;

  logic clk = 1'b0, rst_n = 1'b0, phase_hi = 1'b0, mid = 1'b0;
  logic hs, ls, flt;
  int n_chk = 0, n_bad = 0, stor = 0, lcnt = 0, ovl = 0;

  always #2.5 clk = ~clk;

  hb_deadtime_ctrl #(.DEAD_CYC(D), .MIN_ON_CYC(MN), .MAX_DEAD_CYC(MX),
                     .CNT_W(CW), .WD_CYC(WD)) dut_i (
    .clk(clk), .rst_n(rst_n), .phase_hi(phase_hi), .mid_hi(mid),
    .hs_on(hs), .ls_on(ls), .fault(flt));

  always @(negedge clk) begin
    if (hs && ls) ovl++;
    if (ls) begin lcnt = 0; mid = 1'b0; end
    else if (hs) mid = 1'b1;
    else if (!mid) begin
      if (lcnt == stor) mid = 1'b1;
      lcnt++;
    end
  end

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic do_reset();
    int n;
    rst_n = 1'b0; phase_hi = 1'b0;
    repeat (3) @(negedge clk);
    chk(!hs && !ls && !flt, "R1 outputs low in reset", {hs, ls, flt}, 0);
    rst_n = 1'b1;
    n = 0;
    while (!ls && n < 100) begin @(negedge clk); n++; end
    chk(n == D, "R1 first low-side delay", n, D);
  endtask

  task automatic settle();
    phase_hi = 1'b0;
    repeat (MN + 2) @(negedge clk);
  endtask

  task automatic run_cycle(input int s, input int l, output int d1, output int w, output int d2);
    int g;
    @(negedge clk); stor = s; phase_hi = 1'b1;
    g = 0;
    while (ls && g < 200) begin @(negedge clk); g++; end
    d1 = 0;
    while (!hs && d1 < 200) begin d1++; @(negedge clk); end
    w = 0;
    while (hs && w < 400) begin w++; if (w == l) phase_hi = 1'b0; @(negedge clk); end
    d2 = 0;
    while (!ls && d2 < 200) begin d2++; @(negedge clk); end
    settle();
  endtask

  task automatic t_fixed();
    int d1, w, d2;
    run_cycle(0, 10, d1, w, d2);
    chk(d1 == D, "R2 fixed dead time, sense at once", d1, D);
    chk(w == 10, "R5 plain width", w, 10);
    chk(d2 == D, "R4 replay of fixed dead time", d2, D);
  endtask

  task automatic t_storage();
    int d1, w, d2;
    run_cycle(3, 10, d1, w, d2);
    chk(d1 == 3 + D, "R2 storage 3 cycles", d1, 3 + D);
    chk(d2 == 3 + D, "R4 replay storage 3", d2, 3 + D);
    run_cycle(15, 10, d1, w, d2);
    chk(d1 == 15 + D, "R2 storage 15 cycles", d1, 15 + D);
    chk(d2 == 15 + D, "R4 replay storage 15", d2, 15 + D);
  endtask

  task automatic t_timeout();
    int d1, w, d2;
    run_cycle(MX - D, 10, d1, w, d2);
    chk(d1 == MX, "R3 sense exactly at clamp", d1, MX);
    run_cycle(100, 10, d1, w, d2);
    chk(d1 == MX, "R3 missing sense forced", d1, MX);
    chk(d2 == MX, "R3 clamped interval replayed", d2, MX);
    run_cycle(0, 10, d1, w, d2);
    chk(d2 == D, "R4 replay follows new measure", d2, D);
  endtask

  task automatic t_minon();
    int d1, w, d2;
    run_cycle(0, 1, d1, w, d2);
    chk(w == MN, "R5 one-cycle request stretched", w, MN);
    run_cycle(0, 3, d1, w, d2);
    chk(w == MN, "R5 short request stretched", w, MN);
    run_cycle(0, MN, d1, w, d2);
    chk(w == MN, "R5 request equal to minimum", w, MN);
    run_cycle(0, MN + 1, d1, w, d2);
    chk(w == MN + 1, "R5 request above minimum", w, MN + 1);
  endtask

  task automatic t_sat();
    int d1, w, d2;
    run_cycle(0, (1 << CW) + 2, d1, w, d2);
    chk(w == (1 << CW) + 2, "R6 long phase not stretched", w, (1 << CW) + 2);
  endtask

  task automatic t_commit();
    int g, d1, w, d2;
    @(negedge clk); stor = 0; phase_hi = 1'b1;
    g = 0;
    while (ls && g < 200) begin @(negedge clk); g++; end
    phase_hi = 1'b0;
    d1 = 0;
    while (!hs && d1 < 200) begin d1++; @(negedge clk); end
    w = 0;
    while (hs && w < 400) begin w++; @(negedge clk); end
    d2 = 0;
    while (!ls && d2 < 200) begin d2++; @(negedge clk); end
    chk(d1 == D, "R10 high side still turns on", d1, D);
    chk(w == MN, "R10 committed phase held minimum", w, MN);
    settle();
  endtask

  task automatic t_wd_restart();
    int d1, w, d2;
    repeat (10) run_cycle(0, 1, d1, w, d2);
    chk(flt == 1'b0, "R8 clean phases restart watchdog", flt, 0);
  endtask

  task automatic t_wd_trip();
    int g, bad;
    bit early;
    stor = 0; early = 1'b0;
    repeat (WD - 2) begin
      @(negedge clk); phase_hi = ~phase_hi;
      if (flt) early = 1'b1;
    end
    chk(!early, "R7 no trip before window", early, 0);
    g = 0;
    while (!flt && g < 400) begin @(negedge clk); phase_hi = ~phase_hi; g++; end
    chk(flt == 1'b1, "R7 watchdog trips", flt, 1);
    bad = 0;
    repeat (40) begin
      @(negedge clk); phase_hi = ~phase_hi;
      if (hs || ls || !flt) bad++;
    end
    chk(bad == 0, "R9 outputs low, fault held", bad, 0);
    do_reset();
    chk(flt == 1'b0, "R9 reset clears fault", flt, 0);
    settle();
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    do_reset();
    settle();
    t_fixed();
    t_storage();
    t_timeout();
    t_minon();
    t_sat();
    t_commit();
    t_wd_restart();
    t_wd_trip();
    chk(ovl == 0, "R1 outputs never both high", ovl, 0);
    summary();
    $finish;
  end
endmodule